// File: doc/BRIEF.md
# Register-Mapped Signed Divider

This block is a signed integer division unit sitting on a 32-bit peripheral register bus. Software loads a divisor and then writes a dividend. Writing the dividend is what starts the operation. Two start registers choose the operand width. A write to the single-word dividend register runs a 32-by-32 division. A write to the low dividend word runs a 64-by-32 division, and the high word is taken from the register that software filled earlier.

The quotient is truncated toward zero, and the remainder carries the sign of the dividend. Each result appears in a primary register and also in a mirror register, so software can read it at either address. A 64-by-32 quotient that does not fit in a signed 32-bit word is clamped to the nearest representable extreme. A zero divisor clears the result registers instead of raising a fault.

The datapath is a restoring divider that retires one quotient bit per clock. A busy output stays high until the results have been written back.

Top module: `sdiv_mmio`

## Requirements
- R1: After reset, every register reads zero and busy_o is low.
- R2: The byte offsets 0x100 (divisor), 0x104 (single dividend), 0x110 (high word / remainder), 0x114 (low word / quotient), 0x118 (remainder mirror) and 0x11C (quotient mirror) can be written while idle and read back. Any other offset reads zero. While the block is idle and no write occurs, the result registers hold their values.
- R3: A write to 0x104 or 0x114 while idle starts a division. busy_o is high from the next cycle for exactly 2*DW+1 cycles, which is 65 at the default width.
- R4: In 32-by-32 mode, the quotient, truncated toward zero, goes to 0x104, 0x114 and 0x11C. The remainder goes to 0x110 and 0x118. The remainder has the dividend's sign and a magnitude below that of the divisor.
- R5: A write to 0x114 divides the 64-bit value {0x110, written word} by the divisor. The quotient goes to 0x114 and 0x11C, the remainder goes to 0x110 and 0x118, and 0x104 is left unchanged.
- R6: In 64-by-32 mode, a quotient outside the signed 32-bit range is written as 0x7FFFFFFF when the true quotient is positive and as 0x80000000 when it is negative.
- R7: In 32-by-32 mode, 0x80000000 divided by 0xFFFFFFFF yields the quotient 0x80000000 and the remainder 0, with no clamping.
- R8: With a zero divisor, 0x110, 0x114, 0x118 and 0x11C all become zero. In 32-by-32 mode, 0x104 keeps the dividend that was written.
- R9: While busy_o is high, bus writes are ignored. Reads return the values held before the start, except that the start register shows the dividend just written.
- R10: When a division completes, 0x118 equals 0x110 and 0x11C equals 0x114.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | AW | Byte address within the register window |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i, combinational |
| busy_o | output | 1 | Division in progress |

## Verification
The hardest cases to reach are the edges of the 64-by-32 range, where the quotient lies at or just beyond the signed 32-bit limits and where the magnitude of the dividend's most negative value exceeds its own signed range. Random operands almost never land there. The stimulus therefore builds high words on purpose: sign extensions of the low word, small positive values and all-ones. These are mixed with directed operands that sit exactly on 0x80000000 and one step beyond it. Writes and reads issued in the middle of a run confirm that nothing changes until completion.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int unsigned OFF_DVSR = 'h100;
  localparam int unsigned OFF_DVND = 'h104;
  localparam int unsigned OFF_NHI  = 'h110;
  localparam int unsigned OFF_NLO  = 'h114;
  localparam int unsigned OFF_RMIR = 'h118;
  localparam int unsigned OFF_QMIR = 'h11C;

  typedef enum logic {MODE_W32 = 1'b0, MODE_W64 = 1'b1} div_mode_e;
endpackage

// File: rtl/sdiv_core.sv
// Unsigned restoring divider, one quotient bit per clock.
module sdiv_core #(
  parameter int unsigned DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2*DW-1:0] num_i,
  input  logic [DW-1:0]   den_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [2*DW-1:0] quo_o,
  output logic [DW-1:0]   rem_o
);
  localparam int unsigned NW = 2 * DW;
  localparam int unsigned CW = $clog2(NW);

  logic [NW-1:0] quo_q;
  logic [DW-1:0] rem_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [DW:0]   shift_w, diff_w;
  logic          ge_w;

  assign shift_w = {rem_q, quo_q[NW-1]};
  assign diff_w  = shift_w - {1'b0, den_q};
  assign ge_w    = shift_w >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      quo_q  <= num_i;
      rem_q  <= '0;
      den_q  <= den_i;
      cnt_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      quo_q <= {quo_q[NW-2:0], ge_w};
      rem_q <= ge_w ? diff_w[DW-1:0] : shift_w[DW-1:0];
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(NW - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/sdiv_fix.sv
// Sign restore, 64/32 saturation, zero-divisor clearing.
module sdiv_fix #(
  parameter int unsigned DW = 32
) (
  input  logic [2*DW-1:0] q_mag_i,
  input  logic [DW-1:0]   r_mag_i,
  input  logic            q_neg_i,
  input  logic            r_neg_i,
  input  logic            wide_i,
  input  logic            dz_i,
  output logic [DW-1:0]   q_o,
  output logic [DW-1:0]   r_o
);
  localparam int unsigned NW = 2 * DW;

  logic [NW-1:0]    q_sgn;
  logic [NW-DW:0]   q_top;
  logic             ovf;
  logic [DW-1:0]    q_sat;

  assign q_sgn = q_neg_i ? (~q_mag_i + 1'b1) : q_mag_i;
  assign q_top = q_sgn[NW-1:DW-1];
  assign ovf   = wide_i && !((&q_top) || (~|q_top));
  assign q_sat = q_neg_i ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};

  always_comb begin
    if (dz_i) begin
      q_o = '0;
      r_o = '0;
    end else begin
      q_o = ovf ? q_sat : q_sgn[DW-1:0];
      r_o = r_neg_i ? (~r_mag_i + 1'b1) : r_mag_i;
    end
  end
endmodule

// File: rtl/sdiv_mmio.sv
module sdiv_mmio
  import sdiv_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o
);
  localparam int unsigned NW = 2 * DW;

  logic [DW-1:0] dvsr_q, dvnd_q, nhi_q, nlo_q, rmir_q, qmir_q;
  logic [AW-1:0] addr_w;
  logic          wr_ok, wr_dvsr, wr_dvnd, wr_nhi, wr_nlo, wr_rmir, wr_qmir, start_w;
  logic [NW-1:0] num_w, num_mag;
  logic [DW-1:0] den_mag;
  div_mode_e     mode_q;
  logic          qneg_q, rneg_q, dz_q;
  logic          core_busy, core_done;
  logic [NW-1:0] q_mag;
  logic [DW-1:0] r_mag, q_res, r_res;

  assign addr_w  = {addr_i[AW-1:2], 2'b00};
  assign wr_ok   = we_i && !busy_o;
  assign wr_dvsr = wr_ok && (addr_w == AW'(OFF_DVSR));
  assign wr_dvnd = wr_ok && (addr_w == AW'(OFF_DVND));
  assign wr_nhi  = wr_ok && (addr_w == AW'(OFF_NHI));
  assign wr_nlo  = wr_ok && (addr_w == AW'(OFF_NLO));
  assign wr_rmir = wr_ok && (addr_w == AW'(OFF_RMIR));
  assign wr_qmir = wr_ok && (addr_w == AW'(OFF_QMIR));
  assign start_w = wr_dvnd || wr_nlo;

  assign num_w   = wr_nlo ? {nhi_q, wdata_i} : {{DW{wdata_i[DW-1]}}, wdata_i};
  assign num_mag = num_w[NW-1] ? (~num_w + 1'b1) : num_w;
  assign den_mag = dvsr_q[DW-1] ? (~dvsr_q + 1'b1) : dvsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_W32;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      dz_q   <= 1'b0;
    end else if (start_w) begin
      mode_q <= wr_nlo ? MODE_W64 : MODE_W32;
      qneg_q <= num_w[NW-1] ^ dvsr_q[DW-1];
      rneg_q <= num_w[NW-1];
      dz_q   <= (dvsr_q == '0);
    end
  end

  sdiv_core #(.DW(DW)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_w),
    .num_i  (num_mag),
    .den_i  (den_mag),
    .busy_o (core_busy),
    .done_o (core_done),
    .quo_o  (q_mag),
    .rem_o  (r_mag)
  );

  sdiv_fix #(.DW(DW)) u_fix (
    .q_mag_i(q_mag),
    .r_mag_i(r_mag),
    .q_neg_i(qneg_q),
    .r_neg_i(rneg_q),
    .wide_i (mode_q == MODE_W64),
    .dz_i   (dz_q),
    .q_o    (q_res),
    .r_o    (r_res)
  );

  assign busy_o = core_busy || core_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvsr_q <= '0;
      dvnd_q <= '0;
      nhi_q  <= '0;
      nlo_q  <= '0;
      rmir_q <= '0;
      qmir_q <= '0;
    end else if (core_done) begin
      nhi_q  <= r_res;
      nlo_q  <= q_res;
      rmir_q <= r_res;
      qmir_q <= q_res;
      if (mode_q == MODE_W32 && !dz_q) dvnd_q <= q_res;
    end else begin
      if (wr_dvsr) dvsr_q <= wdata_i;
      if (wr_dvnd) dvnd_q <= wdata_i;
      if (wr_nhi)  nhi_q  <= wdata_i;
      if (wr_nlo)  nlo_q  <= wdata_i;
      if (wr_rmir) rmir_q <= wdata_i;
      if (wr_qmir) qmir_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if      (addr_w == AW'(OFF_DVSR)) rdata_o = dvsr_q;
    else if (addr_w == AW'(OFF_DVND)) rdata_o = dvnd_q;
    else if (addr_w == AW'(OFF_NHI))  rdata_o = nhi_q;
    else if (addr_w == AW'(OFF_NLO))  rdata_o = nlo_q;
    else if (addr_w == AW'(OFF_RMIR)) rdata_o = rmir_q;
    else if (addr_w == AW'(OFF_QMIR)) rdata_o = qmir_q;
  end
endmodule

// File: rtl/sdiv_mmio_chk.sv
module sdiv_mmio_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic          busy_i,
  input logic [DW-1:0] dvsr_i,
  input logic [DW-1:0] nhi_i,
  input logic [DW-1:0] nlo_i,
  input logic [DW-1:0] rmir_i,
  input logic [DW-1:0] qmir_i
);
  logic [AW-1:0] addr_w;
  logic          trig_w;
  logic [DW-1:0] rm_abs, dv_abs;

  assign addr_w = {addr_i[AW-1:2], 2'b00};
  assign trig_w = (addr_w == AW'('h104)) || (addr_w == AW'('h114));
  assign rm_abs = rmir_i[DW-1] ? (~rmir_i + 1'b1) : rmir_i;
  assign dv_abs = dvsr_i[DW-1] ? (~dvsr_i + 1'b1) : dvsr_i;

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && we_i && trig_w) |=> busy_i); // R3

  AST_BUSY_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && we_i) |=> $stable(dvsr_i)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !we_i) |=> ($stable(rmir_i) && $stable(qmir_i))); // R2

  AST_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (rmir_i == nhi_i && qmir_i == nlo_i)); // R10

  AST_ZERO_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_i) && dvsr_i == '0) |-> (rmir_i == '0 && qmir_i == '0)); // R8

  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_i) && dvsr_i != '0) |-> (rm_abs < dv_abs)); // R4
endmodule

bind sdiv_mmio sdiv_mmio_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .we_i  (we_i),
  .addr_i(addr_i),
  .busy_i(busy_o),
  .dvsr_i(dvsr_q),
  .nhi_i (nhi_q),
  .nlo_i (nlo_q),
  .rmir_i(rmir_q),
  .qmir_i(qmir_q)
);

// File: tb/sdiv_mmio_bench.sv
`timescale 1ns/1ps
module sdiv_mmio_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] sh104 = '0;

  always #2.5 clk = ~clk;

  sdiv_mmio u_sdiv_mmio (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .busy_o (busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic void model(input logic wide, input logic [31:0] hi, input logic [31:0] lo,
                                input logic [31:0] dv, output logic [31:0] eq,
                                output logic [31:0] er, output logic ovf);
    logic [63:0] n, nm, dm, q, r;
    logic nn, dn, qn;
    ovf = 1'b0;
    if (dv == 32'h0) begin
      eq = '0; er = '0;
      return;
    end
    n  = wide ? {hi, lo} : {{32{lo[31]}}, lo};
    nn = n[63];
    dn = dv[31];
    qn = nn ^ dn;
    nm = nn ? -n : n;
    dm = {32'h0, dn ? -dv : dv};
    q  = nm / dm;
    r  = nm % dm;
    eq = qn ? -q[31:0] : q[31:0];
    er = nn ? -r[31:0] : r[31:0];
    if (wide) begin
      ovf = qn ? (q > 64'h80000000) : (q > 64'h7FFFFFFF);
      if (ovf) eq = qn ? 32'h80000000 : 32'h7FFFFFFF;
    end
  endfunction

  task automatic wait_idle(output int cyc);
    cyc = 0;
    @(negedge clk);
    while (busy && cyc < 500) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic run_div(input logic wide, input logic [31:0] hi, input logic [31:0] lo,
                         input logic [31:0] dv, input string qtag);
    logic [31:0] eq, er, v;
    logic ovf;
    int cyc;
    model(wide, hi, lo, dv, eq, er, ovf);
    wr(9'h100, dv);
    if (wide) begin
      wr(9'h110, hi);
      wr(9'h114, lo);
    end else begin
      wr(9'h104, lo);
    end
    wait_idle(cyc);
    check("R3 busy length", 32'(cyc), 32'd65);
    rd(9'h114, v); check(ovf ? "R6 quotient" : qtag, v, eq);
    rd(9'h11C, v); check("R10 quotient mirror", v, eq);
    rd(9'h110, v); check(dv == 0 ? "R8 remainder" : (wide ? "R5 remainder" : "R4 remainder"), v, er);
    rd(9'h118, v); check("R10 remainder mirror", v, er);
    if (!wide) sh104 = (dv == 0) ? lo : eq;
    rd(9'h104, v); check(wide ? "R5 0x104 kept" : (dv == 0 ? "R8 dividend kept" : "R4 0x104"), v, sh104);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cyc;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 busy", 32'(busy), 32'd0);
    foreach (v[i]) begin end
    rd(9'h100, v); check("R1 0x100", v, 0);
    rd(9'h104, v); check("R1 0x104", v, 0);
    rd(9'h110, v); check("R1 0x110", v, 0);
    rd(9'h114, v); check("R1 0x114", v, 0);
    rd(9'h118, v); check("R1 0x118", v, 0);
    rd(9'h11C, v); check("R1 0x11C", v, 0);

    // R2 register access
    wr(9'h100, 32'h1234_5678); rd(9'h100, v); check("R2 divisor rw", v, 32'h1234_5678);
    wr(9'h110, 32'hCAFE_0001); rd(9'h110, v); check("R2 high rw", v, 32'hCAFE_0001);
    wr(9'h108, 32'hFFFF_FFFF); rd(9'h108, v); check("R2 unmapped", v, 0);

    // R4 sign combinations
    run_div(0, 0, 32'd7, 32'd2, "R4 quotient");
    run_div(0, 0, -32'd7, 32'd2, "R4 quotient");
    run_div(0, 0, 32'd7, -32'd2, "R4 quotient");
    run_div(0, 0, -32'd7, -32'd2, "R4 quotient");
    // R7 wrap case
    run_div(0, 0, 32'h8000_0000, 32'hFFFF_FFFF, "R7 quotient");
    // R8 zero divisor both modes
    run_div(0, 0, 32'd99, 32'd0, "R8 quotient");
    run_div(1, 32'd5, 32'd99, 32'd0, "R8 quotient");
    // R5 / R6 boundaries
    run_div(1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, "R5 quotient");
    run_div(1, 32'h0, 32'h7FFF_FFFF, 32'd1, "R5 quotient");
    run_div(1, 32'h0, 32'h8000_0000, 32'd1, "R6 quotient");
    run_div(1, 32'd1, 32'h0, 32'hFFFF_FFFF, "R6 quotient");
    run_div(1, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, "R6 quotient");
    run_div(1, 32'h0000_0123, 32'h4567_89AB, 32'h1000_0000, "R5 quotient");

    // R9 writes and reads during a run
    wr(9'h118, 32'h5555_AAAA);
    wr(9'h100, -32'd7);
    wr(9'h104, 32'd100);
    wr(9'h100, 32'd3);
    wr(9'h118, 32'h0BAD_F00D);
    rd(9'h118, v); check("R9 mirror held", v, 32'h5555_AAAA);
    rd(9'h104, v); check("R9 start reg shows dividend", v, 32'd100);
    check("R9 still busy", 32'(busy), 32'd1);
    wait_idle(cyc);
    rd(9'h100, v); check("R9 divisor unchanged", v, -32'd7);
    rd(9'h114, v); check("R9 quotient", v, -32'd14);
    rd(9'h110, v); check("R9 remainder", v, 32'd2);
    sh104 = -32'd14;

    // random
    for (int i = 0; i < 60; i++) begin
      logic [31:0] lo, hi, dv;
      logic wide;
      wide = 1'($urandom % 2);
      lo = $urandom;
      case ($urandom % 4)
        0: hi = {32{lo[31]}};
        1: hi = $urandom;
        2: hi = $urandom % 8;
        default: hi = 32'hFFFF_FFFF;
      endcase
      case ($urandom % 3)
        0: dv = $urandom;
        1: dv = $urandom % 16;
        default: dv = $urandom % 32'h10000;
      endcase
      if ($urandom % 2) dv = -dv;
      run_div(wide, hi, lo, dv, wide ? "R5 quotient" : "R4 quotient");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule